// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Classifier

This block sits behind a coarse, bank-level change interrupt. It finds out which single pins produced an edge of the kind they are set up for. It keeps a snapshot of the pin vector as it was at the last evaluation. On an evaluate strobe it compares the live pins with that snapshot and reports per-pin rising and falling hits. It then overwrites the snapshot with the live pins.

Each pin carries three bits of configuration:
- an enable bit,
- a rising-select bit,
- a falling-select bit.

The pins are grouped into 32-pin banks. A bank's interrupt enable follows whether any of its pins is enabled. A bank's pending flag records that a pin in an enabled bank changed. Enabling the first pin of a bank clears that bank's pending flag and resamples that bank's snapshot, so edges that happened before the unmask are not reported.

Top module: `pin_edge_classifier`

## Requirements
- R1: After reset, all of the following are zero: every hit vector, `done_o`, `cfg_err_o`, every bank enable and every pending flag. All enable bits, select bits and the snapshot are also zero.
- R2: One cycle after `eval_i`, `rise_o[i]` is 1 exactly when the snapshot bit was 0, the pin reads 1, the pin is enabled and its rising select is set. `done_o` pulses in that cycle. In every cycle without a preceding evaluate, all hit vectors are zero.
- R3: One cycle after `eval_i`, `fall_o[i]` is 1 exactly when the snapshot bit was 1, the pin reads 0, the pin is enabled and its falling select is set.
- R4: `hit_o` is the OR of `rise_o` and `fall_o`. Each evaluation replaces the whole snapshot with the pins sampled in that cycle, so a second evaluation with unchanged pins reports no hits.
- R5: A write with `cfg_type_i` of 2'b01 selects rising only, 2'b10 selects falling only and 2'b11 selects both edges. Bit 0 is the rising select and bit 1 is the falling select. The code 2'b00 requests level sensitivity. It is rejected: `cfg_err_o` pulses in the next cycle and both select bits of that pin keep their values.
- R6: Setting the enable of a pin whose bank had no enabled pin does three things. It clears that bank's pending flag. It loads that bank's snapshot from the current pins. It raises that bank's `bank_en_o` bit in the next cycle.
- R7: Clearing an enable bit drops the bank's `bank_en_o` bit in the next cycle only if no other pin of that bank remains enabled.
- R8: Pin p belongs to bank p/32: bank 0 holds pins 0 to 31 and bank 1 holds pins 32 to 63.
- R9: `pend_o[b]` becomes 1 in the cycle after any pin of bank b changes value while `bank_en_o[b]` is 1. An evaluate clears it, unless a change is seen in the same cycle.
- R10: An evaluate strobe in the same cycle as a configuration or enable write uses the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 64 | Live pin vector |
| eval_i | input | 1 | Evaluate strobe |
| cfg_we_i | input | 1 | Edge-type write strobe |
| cfg_pin_i | input | 6 | Pin index for the edge-type write |
| cfg_type_i | input | 2 | Edge type: 01 rising, 10 falling, 11 both, 00 level (rejected) |
| en_we_i | input | 1 | Enable-bit write strobe (unmask or mask) |
| en_pin_i | input | 6 | Pin index for the enable write |
| en_val_i | input | 1 | 1 unmasks the pin, 0 masks it |
| rise_o | output | 64 | Registered rising hits |
| fall_o | output | 64 | Registered falling hits |
| hit_o | output | 64 | Union of the rising and falling hits |
| done_o | output | 1 | Pulse marking valid hit vectors |
| cfg_err_o | output | 1 | Pulse after a rejected level request |
| bank_en_o | output | 2 | Per-bank interrupt enable |
| pend_o | output | 2 | Per-bank pending change flag |

## Verification
Several actions can land in one clock cycle:
- an evaluate strobe together with an edge-type write or an enable write to the same pin;
- an evaluate together with a first-in-bank unmask, where both reload the snapshot;
- an evaluate together with a pin change, where the pending clear and the pending set compete.

Directed steps place these pairs in a single cycle. The random phase draws all strobes independently every cycle, so such collisions recur many times. Every cycle, a bench-side model built from the requirements predicts the hit vectors, flags and bank enables. The model uses the pre-write configuration for the evaluation, and the outputs are compared against it.

// File: rtl/pin_edge_classifier.sv
module pin_edge_classifier #(
  parameter int NPINS  = 64,
  parameter int BANK_W = 32,
  localparam int NBANK  = (NPINS + BANK_W - 1) / BANK_W,
  localparam int PIDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              eval_i,
  input  logic              cfg_we_i,
  input  logic [PIDX_W-1:0] cfg_pin_i,
  input  logic [1:0]        cfg_type_i,
  input  logic              en_we_i,
  input  logic [PIDX_W-1:0] en_pin_i,
  input  logic              en_val_i,
  output logic [NPINS-1:0]  rise_o,
  output logic [NPINS-1:0]  fall_o,
  output logic [NPINS-1:0]  hit_o,
  output logic              done_o,
  output logic              cfg_err_o,
  output logic [NBANK-1:0]  bank_en_o,
  output logic [NBANK-1:0]  pend_o
);
  localparam int PADW = NBANK * BANK_W;

  logic [NPINS-1:0] snap, en, rsel, fsel, pins_q, en_nx, refresh;
  logic [PADW-1:0]  en_pad, chg_pad;
  logic [NBANK-1:0] first, chg, any_en;

  always_comb begin
    en_nx = en;
    if (en_we_i) en_nx[en_pin_i] = en_val_i;
    en_pad  = '0;
    chg_pad = '0;
    en_pad[NPINS-1:0]  = en_nx;
    chg_pad[NPINS-1:0] = pins_i ^ pins_q;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign any_en[b] = |en_pad[b*BANK_W +: BANK_W];
    assign chg[b]    = |chg_pad[b*BANK_W +: BANK_W];
    assign first[b]  = en_we_i && en_val_i && !bank_en_o[b] &&
                       (int'(en_pin_i) / BANK_W == b);
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign refresh[i] = eval_i | first[i / BANK_W];
  end

  logic rej;
  assign rej = cfg_we_i && (cfg_type_i == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap <= '0; en <= '0; rsel <= '0; fsel <= '0; pins_q <= '0;
      rise_o <= '0; fall_o <= '0; done_o <= 1'b0; cfg_err_o <= 1'b0;
      bank_en_o <= '0; pend_o <= '0;
    end else begin
      rise_o    <= eval_i ? (~snap & pins_i & en & rsel) : '0;
      fall_o    <= eval_i ? (snap & ~pins_i & en & fsel) : '0;
      done_o    <= eval_i;
      cfg_err_o <= rej;
      snap      <= (snap & ~refresh) | (pins_i & refresh);
      en        <= en_nx;
      bank_en_o <= any_en;
      pins_q    <= pins_i;
      pend_o    <= ~first & ((pend_o & ~{NBANK{eval_i}}) | (chg & bank_en_o));
      if (cfg_we_i && !rej) begin
        rsel[cfg_pin_i] <= cfg_type_i[0];
        fsel[cfg_pin_i] <= cfg_type_i[1];
      end
    end
  end

  assign hit_o = rise_o | fall_o;

  a_r2_done_follows_eval: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> done_o);
  a_r2_quiet_without_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (rise_o == '0 && fall_o == '0));
  a_r5_reject_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> (rsel == $past(rsel) && fsel == $past(fsel)));
  a_r6_unmask_raises_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (first != '0) |=> ((bank_en_o & $past(first)) == $past(first)));
  a_r9_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~$past(pend_o) & ~$past(bank_en_o)) == '0));
endmodule

// File: tb/pin_edge_classifier_tb.sv
module pin_edge_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pins_i = '0;
  logic        eval_i = 0, cfg_we_i = 0, en_we_i = 0, en_val_i = 0;
  logic [5:0]  cfg_pin_i = '0, en_pin_i = '0;
  logic [1:0]  cfg_type_i = '0;
  logic [63:0] rise_o, fall_o, hit_o;
  logic        done_o, cfg_err_o;
  logic [1:0]  bank_en_o, pend_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [63:0] m_snap = '0, m_en = '0, m_rs = '0, m_fs = '0, m_pq = '0;
  logic [63:0] e_rise = '0, e_fall = '0;
  logic        e_done = 0, e_err = 0;
  logic [1:0]  m_ben = '0, m_pend = '0;

  always #4 clk = ~clk;

  pin_edge_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .eval_i(eval_i),
    .cfg_we_i(cfg_we_i), .cfg_pin_i(cfg_pin_i), .cfg_type_i(cfg_type_i),
    .en_we_i(en_we_i), .en_pin_i(en_pin_i), .en_val_i(en_val_i),
    .rise_o(rise_o), .fall_o(fall_o), .hit_o(hit_o), .done_o(done_o),
    .cfg_err_o(cfg_err_o), .bank_en_o(bank_en_o), .pend_o(pend_o));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    check("R2 rise", rise_o, e_rise);
    check("R3 fall", fall_o, e_fall);
    check("R4 hit", hit_o, e_rise | e_fall);
    check("R2 done", 64'(done_o), 64'(e_done));
    check("R5 err", 64'(cfg_err_o), 64'(e_err));
    check("R6 bank_en", 64'(bank_en_o), 64'(m_ben)); // also R7
    check("R9 pend", 64'(pend_o), 64'(m_pend));
  endtask

  task automatic step(logic [63:0] p, bit ev, bit cw, int cp, logic [1:0] ct,
                      bit ew, int ep, bit ev_val);
    logic [63:0] en_n, mask;
    logic [1:0]  first, chg, ben_n, pend_n;
    @(negedge clk);
    pins_i = p; eval_i = ev; cfg_we_i = cw; cfg_pin_i = 6'(cp); cfg_type_i = ct;
    en_we_i = ew; en_pin_i = 6'(ep); en_val_i = ev_val;
    // bank of a pin is index/32 (R8)
    en_n = m_en;
    if (ew) en_n[ep] = ev_val;
    for (int b = 0; b < 2; b++) begin
      first[b]  = ew && ev_val && (ep / 32 == b) && !m_ben[b];
      chg[b]    = ((p ^ m_pq) >> (32 * b)) & 64'hFFFF_FFFF ? 1'b1 : 1'b0;
      ben_n[b]  = (en_n >> (32 * b)) & 64'hFFFF_FFFF ? 1'b1 : 1'b0;
      pend_n[b] = first[b] ? 1'b0 : ((m_pend[b] && !ev) || (chg[b] && m_ben[b]));
    end
    // R10: evaluation uses the configuration before this cycle's writes
    e_rise = ev ? (~m_snap & p & m_en & m_rs) : '0;
    e_fall = ev ? (m_snap & ~p & m_en & m_fs) : '0;
    e_done = ev;
    e_err  = cw && ct == 2'b00;
    mask = ev ? '1 : '0;
    if (first[0]) mask[31:0]  = '1;
    if (first[1]) mask[63:32] = '1;
    m_snap = (m_snap & ~mask) | (p & mask);
    if (cw && ct != 2'b00) begin
      m_rs[cp] = ct[0];
      m_fs[cp] = ct[1];
    end
    m_en = en_n; m_ben = ben_n; m_pend = pend_n; m_pq = p;
    @(posedge clk);
    #2;
    check_all();
  endtask

  task automatic idle(logic [63:0] p);
    step(p, 0, 0, 0, 2'b00, 0, 0, 0);
  endtask

  initial begin
    logic [63:0] p;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1 rise", rise_o, '0);
    check("R1 fall", fall_o, '0);
    check("R1 flags", {60'd0, done_o, cfg_err_o, bank_en_o}, '0);
    check("R1 pend", 64'(pend_o), '0);
    @(negedge clk);
    rst_n = 1'b1;
    p = '0;
    idle(p);
    // R5 rising select on pin 3, R6 first unmask in bank 0
    step(p, 0, 1, 3, 2'b01, 1, 3, 1);
    p[3] = 1'b1;
    idle(p); // R9 pending set
    step(p, 1, 0, 0, 2'b00, 0, 0, 0); // R2 rising hit
    step(p, 1, 0, 0, 2'b00, 0, 0, 0); // R4 snapshot replaced, no hit
    // R3 falling on pin 40, first unmask in bank 1 resamples high level
    p[40] = 1'b1;
    idle(p);
    step(p, 0, 1, 40, 2'b10, 1, 40, 1);
    p[40] = 1'b0;
    step(p, 1, 0, 0, 2'b00, 0, 0, 0);
    // R5 level request rejected on pin 3, rising still active
    step(p, 0, 1, 3, 2'b00, 0, 0, 0);
    p[3] = 1'b0;
    step(p, 1, 0, 0, 2'b00, 0, 0, 0);
    p[3] = 1'b1;
    step(p, 1, 0, 0, 2'b00, 0, 0, 0);
    // R10: evaluate with simultaneous retype and mask of pin 3
    p[3] = 1'b0;
    step(p, 1, 1, 3, 2'b11, 0, 0, 0);
    p[3] = 1'b1;
    step(p, 1, 1, 3, 2'b10, 1, 3, 0);
    // R7: bank 0 now empty; R8 boundary pins 31 and 32
    step(p, 0, 0, 0, 2'b00, 1, 31, 1);
    step(p, 0, 0, 0, 2'b00, 1, 32, 1);
    step(p, 0, 0, 0, 2'b00, 1, 31, 0);
    step(p, 0, 0, 0, 2'b00, 1, 40, 0);
    step(p, 0, 0, 0, 2'b00, 1, 32, 0);
    // random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] flip;
      flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(0, 2) != 0) flip = '0;
      p = p ^ flip;
      step(p, $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
           $urandom_range(0, 63), 2'($urandom_range(0, 3)),
           $urandom_range(0, 3) == 0, $urandom_range(0, 63),
           $urandom_range(0, 2) != 0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule